// File: doc/BRIEF.md
# Ranked Candidate Sorter with Deterministic Tie Resolution

This block picks the best few candidates out of a fixed set of detector candidates and presents them in descending rank order. Each candidate arrives as a packed record holding a transverse-momentum field, a data payload, a sort rank and auxiliary flag bits. A record whose momentum field is zero counts as empty. The candidates arrive grouped by detector region. The block joins them into one vector in a fixed signed-region order, so that every candidate has a stable index.

Every candidate is compared with every other one. A candidate beats another when its rank is higher, or when the ranks are equal and its index is lower. An empty candidate never beats a filled one. The number of comparisons a candidate wins gives its output position directly. The leading positions are registered once and appear one cycle after the input. Each output slot carries the winner's payload, rank, joined index and empty bit. A slot with no filled winner is cleared.

Top module: `rank_sorter`

## Requirements
- R1: Each input record is 25 bits wide: momentum in bits [8:0], data in [16:9], rank in [22:17] and auxiliary bits in [24:23]. Record k of a region bus sits in bits [k*25 +: 25]. The joined index runs forward-positive 0..1, overlap-positive 2, central 3..4, overlap-negative 5, forward-negative 6..7.
- R2: Among the non-empty output slots, slot 0 holds the highest rank and the ranks never increase from one slot to the next.
- R3: When two candidates have equal rank, the one with the lower joined index lands in the earlier slot. The same rule applies regardless of region.
- R4: A candidate with a zero momentum field is empty. It never occupies a slot ahead of a non-empty candidate, whatever its rank field holds.
- R5: An output slot without a non-empty winner shows `out_empty` = 1 and zero momentum, data, rank, auxiliary bits and index.
- R6: `out_valid` equals `in_valid` delayed by one clock. The slot contents reflect the inputs that were present on the previous rising edge.
- R7: While reset is asserted and after it is released, `out_valid` is 0 and every slot reads as empty with all fields zero.
- R8: Every non-empty slot carries the winner's momentum, data, rank and auxiliary bits unchanged, together with its joined index.
- R9: The number of non-empty output slots equals the smaller of 4 and the number of non-empty inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set is valid this cycle |
| fwd_pos_cand | input | 50 | Forward positive-side records (2) |
| ovl_pos_cand | input | 25 | Overlap positive-side record (1) |
| brl_cand | input | 50 | Central region records (2) |
| ovl_neg_cand | input | 25 | Overlap negative-side record (1) |
| fwd_neg_cand | input | 50 | Forward negative-side records (2) |
| out_valid | output | 1 | Output slots are valid |
| out_pt | output | 36 | Momentum per slot, slot s at [s*9 +: 9] |
| out_data | output | 32 | Data payload per slot, [s*8 +: 8] |
| out_rank | output | 24 | Rank per slot, [s*6 +: 6] |
| out_aux | output | 8 | Auxiliary bits per slot, [s*2 +: 2] |
| out_empty | output | 4 | Empty bit per slot |
| out_index | output | 12 | Joined index per slot, [s*3 +: 3] |

## Verification
The bench goes after equal ranks: all candidates tied, and ties that span different regions. A design that reverses the index rule, or reverses it in only some comparisons, puts a higher index first or loses a candidate because two of them claim the same slot. It also drives empty candidates whose rank field holds the maximum value. A design that sorts on the rank field alone would then place a blank record ahead of real ones. Single filled candidates in each region position expose swapped positive and negative sides through the reported index. All-empty and partly filled input sets check that unused slots are fully cleared, auxiliary bits included.

// File: rtl/rsort_pkg.sv
package rsort_pkg;
    parameter int PT_W   = 9;
    parameter int DATA_W = 8;
    parameter int RANK_W = 6;
    parameter int AUX_W  = 2;
    parameter int FWD_N  = 2;
    parameter int OVL_N  = 1;
    parameter int BRL_N  = 2;

    localparam int N_IN   = 2 * FWD_N + 2 * OVL_N + BRL_N;
    localparam int IDX_W  = $clog2(N_IN);
    localparam int CAND_W = PT_W + DATA_W + RANK_W + AUX_W;

    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic [RANK_W-1:0] rank;
        logic [DATA_W-1:0] data;
        logic [PT_W-1:0]   pt;
    } cand_t;

    typedef struct packed {
        logic             full;
        logic [IDX_W-1:0] idx;
        cand_t            c;
    } slot_t;
endpackage

// File: rtl/rsort_concat.sv
module rsort_concat
    import rsort_pkg::*;
(
    input  logic [FWD_N*CAND_W-1:0] fwd_pos_cand,
    input  logic [OVL_N*CAND_W-1:0] ovl_pos_cand,
    input  logic [BRL_N*CAND_W-1:0] brl_cand,
    input  logic [OVL_N*CAND_W-1:0] ovl_neg_cand,
    input  logic [FWD_N*CAND_W-1:0] fwd_neg_cand,
    output cand_t                   cand [N_IN],
    output logic [N_IN-1:0]         empty
);
    // fixed signed-region order: fwd+, ovl+, central, ovl-, fwd-
    localparam int OFS_OP = FWD_N;
    localparam int OFS_BR = OFS_OP + OVL_N;
    localparam int OFS_ON = OFS_BR + BRL_N;
    localparam int OFS_FN = OFS_ON + OVL_N;

    for (genvar k = 0; k < FWD_N; k++) begin : g_fwd
        assign cand[k]          = cand_t'(fwd_pos_cand[k*CAND_W +: CAND_W]);
        assign cand[OFS_FN + k] = cand_t'(fwd_neg_cand[k*CAND_W +: CAND_W]);
    end
    for (genvar k = 0; k < OVL_N; k++) begin : g_ovl
        assign cand[OFS_OP + k] = cand_t'(ovl_pos_cand[k*CAND_W +: CAND_W]);
        assign cand[OFS_ON + k] = cand_t'(ovl_neg_cand[k*CAND_W +: CAND_W]);
    end
    for (genvar k = 0; k < BRL_N; k++) begin : g_brl
        assign cand[OFS_BR + k] = cand_t'(brl_cand[k*CAND_W +: CAND_W]);
    end
    for (genvar i = 0; i < N_IN; i++) begin : g_empty
        assign empty[i] = (cand[i].pt == '0);
    end
endmodule

// File: rtl/rsort_rank_matrix.sv
module rsort_rank_matrix
    import rsort_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  cand_t                cand [N_IN],
    input  logic [N_IN-1:0]      empty,
    output logic [IDX_W-1:0]     pos  [N_IN]
);
    logic [N_IN-1:0] beats [N_IN];

    // beats[i][j]: i outranks j; equal rank goes to the lower index
    for (genvar i = 0; i < N_IN; i++) begin : g_row
        for (genvar j = 0; j < N_IN; j++) begin : g_col
            if (i == j) begin : g_self
                assign beats[i][j] = 1'b0;
            end else if (i < j) begin : g_lo
                assign beats[i][j] = !empty[i] &&
                    (empty[j] || cand[i].rank >= cand[j].rank);
            end else begin : g_hi
                assign beats[i][j] = empty[j] ||
                    (!empty[i] && cand[i].rank > cand[j].rank);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            pos[i] = IDX_W'(N_IN - 1) - IDX_W'($countones(beats[i]));
        end
    end

    // every output position is claimed by exactly one candidate
    for (genvar s = 0; s < N_IN; s++) begin : g_chk
        logic [N_IN-1:0] hit;
        for (genvar i = 0; i < N_IN; i++) begin : g_hit
            assign hit[i] = (pos[i] == IDX_W'(s));
        end
        assert_pos_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit) == 1);
    end
endmodule

// File: rtl/rsort_select.sv
module rsort_select
    import rsort_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  cand_t             cand [N_IN],
    input  logic [N_IN-1:0]   empty,
    input  logic [IDX_W-1:0]  pos  [N_IN],
    output slot_t             slot [N_OUT]
);
    always_comb begin
        for (int s = 0; s < N_OUT; s++) begin
            slot_t acc;
            acc = '0;
            for (int i = 0; i < N_IN; i++) begin
                if (pos[i] == IDX_W'(s)) begin
                    acc.c    = acc.c | cand[i];
                    acc.idx  = acc.idx | IDX_W'(i);
                    acc.full = acc.full | !empty[i];
                end
            end
            if (!acc.full) begin
                acc = '0;
            end
            slot[s] = acc;
        end
    end
endmodule

// File: rtl/rank_sorter.sv
module rank_sorter
    import rsort_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [FWD_N*CAND_W-1:0] fwd_pos_cand,
    input  logic [OVL_N*CAND_W-1:0] ovl_pos_cand,
    input  logic [BRL_N*CAND_W-1:0] brl_cand,
    input  logic [OVL_N*CAND_W-1:0] ovl_neg_cand,
    input  logic [FWD_N*CAND_W-1:0] fwd_neg_cand,
    output logic                    out_valid,
    output logic [N_OUT*PT_W-1:0]   out_pt,
    output logic [N_OUT*DATA_W-1:0] out_data,
    output logic [N_OUT*RANK_W-1:0] out_rank,
    output logic [N_OUT*AUX_W-1:0]  out_aux,
    output logic [N_OUT-1:0]        out_empty,
    output logic [N_OUT*IDX_W-1:0]  out_index
);
    typedef struct packed {
        logic                   valid;
        slot_t [N_OUT-1:0]      slot;
    } state_t;

    cand_t            cand [N_IN];
    logic [N_IN-1:0]  in_empty;
    logic [IDX_W-1:0] pos  [N_IN];
    slot_t            win  [N_OUT];
    state_t           state_d, state_q;

    rsort_concat i_concat (
        .fwd_pos_cand (fwd_pos_cand),
        .ovl_pos_cand (ovl_pos_cand),
        .brl_cand     (brl_cand),
        .ovl_neg_cand (ovl_neg_cand),
        .fwd_neg_cand (fwd_neg_cand),
        .cand         (cand),
        .empty        (in_empty)
    );

    rsort_rank_matrix i_matrix (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (cand),
        .empty (in_empty),
        .pos   (pos)
    );

    rsort_select #(.N_OUT(N_OUT)) i_select (
        .cand  (cand),
        .empty (in_empty),
        .pos   (pos),
        .slot  (win)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        for (int s = 0; s < N_OUT; s++) begin
            state_d.slot[s] = win[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    for (genvar s = 0; s < N_OUT; s++) begin : g_out
        assign out_pt[s*PT_W +: PT_W]       = state_q.slot[s].c.pt;
        assign out_data[s*DATA_W +: DATA_W] = state_q.slot[s].c.data;
        assign out_rank[s*RANK_W +: RANK_W] = state_q.slot[s].c.rank;
        assign out_aux[s*AUX_W +: AUX_W]    = state_q.slot[s].c.aux;
        assign out_empty[s]                 = !state_q.slot[s].full;
        assign out_index[s*IDX_W +: IDX_W]  = state_q.slot[s].idx;
    end

    // ---------------- assertions ----------------
    int unsigned exp_filled;
    always_comb begin
        exp_filled = $countones(~in_empty);
        if (exp_filled > N_OUT) exp_filled = N_OUT;
    end

    assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_filled_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(~out_empty) == $past(exp_filled)));

    for (genvar s = 0; s < N_OUT; s++) begin : g_slot_chk
        assert_empty_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_empty[s] |-> (state_q.slot[s].c == '0 && state_q.slot[s].idx == '0));
        assert_nonempty_pt_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !out_empty[s] |-> (state_q.slot[s].c.pt != '0));
        if (s + 1 < N_OUT) begin : g_pair
            assert_empty_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
                out_empty[s] |-> out_empty[s+1]);
            assert_rank_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!out_empty[s] && !out_empty[s+1]) |->
                (state_q.slot[s].c.rank > state_q.slot[s+1].c.rank ||
                 (state_q.slot[s].c.rank == state_q.slot[s+1].c.rank &&
                  state_q.slot[s].idx < state_q.slot[s+1].idx)));
        end
    end
endmodule

// File: tb/test_rank_sorter.sv
module test_rank_sorter;
    import rsort_pkg::*;

    localparam int N_OUT = 4;
    localparam int CW    = CAND_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N_IN*CW-1:0] all_in = '0;

    logic                    out_valid;
    logic [N_OUT*PT_W-1:0]   out_pt;
    logic [N_OUT*DATA_W-1:0] out_data;
    logic [N_OUT*RANK_W-1:0] out_rank;
    logic [N_OUT*AUX_W-1:0]  out_aux;
    logic [N_OUT-1:0]        out_empty;
    logic [N_OUT*IDX_W-1:0]  out_index;

    always #4 clk = ~clk;

    rank_sorter #(.N_OUT(N_OUT)) i_rank_sorter (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .fwd_pos_cand (all_in[0 +: 2*CW]),
        .ovl_pos_cand (all_in[2*CW +: CW]),
        .brl_cand     (all_in[3*CW +: 2*CW]),
        .ovl_neg_cand (all_in[5*CW +: CW]),
        .fwd_neg_cand (all_in[6*CW +: 2*CW]),
        .out_valid    (out_valid),
        .out_pt       (out_pt),
        .out_data     (out_data),
        .out_rank     (out_rank),
        .out_aux      (out_aux),
        .out_empty    (out_empty),
        .out_index    (out_index)
    );

    typedef struct {
        bit                      valid;
        string                   req;
        int                      cyc;
        logic [N_OUT*PT_W-1:0]   pt;
        logic [N_OUT*DATA_W-1:0] data;
        logic [N_OUT*RANK_W-1:0] rank;
        logic [N_OUT*AUX_W-1:0]  aux;
        logic [N_OUT-1:0]        empty;
        logic [N_OUT*IDX_W-1:0]  idx;
    } item_t;

    item_t queue_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    cycle  = 0;
    bit    done   = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always @(posedge clk) cycle <= cycle + 1;

    function automatic logic [CW-1:0] mk(input int pt, input int data, input int rank, input int aux);
        return {AUX_W'(aux), RANK_W'(rank), DATA_W'(data), PT_W'(pt)};
    endfunction

    // reference: i is preferred over j (R3, R4)
    function automatic bit better(input logic [CW-1:0] a, input int ia,
                                  input logic [CW-1:0] b, input int ib);
        bit fa, fb;
        fa = (a[PT_W-1:0] != '0);
        fb = (b[PT_W-1:0] != '0);
        if (fa != fb) return fa;
        if (a[PT_W+DATA_W +: RANK_W] != b[PT_W+DATA_W +: RANK_W])
            return a[PT_W+DATA_W +: RANK_W] > b[PT_W+DATA_W +: RANK_W];
        return ia < ib;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [N_IN*CW-1:0] v, input string req);
        item_t it;
        bit used [N_IN];
        @(negedge clk);
        all_in   = v;
        in_valid = 1'b1;
        it.valid = 1'b1;
        it.req   = req;
        it.cyc   = cycle;
        it.pt = '0; it.data = '0; it.rank = '0; it.aux = '0; it.idx = '0;
        it.empty = '1;
        foreach (used[k]) used[k] = 1'b0;
        for (int s = 0; s < N_OUT; s++) begin
            int best;
            best = -1;
            for (int i = 0; i < N_IN; i++) begin
                if (!used[i] && (best < 0 || better(v[i*CW +: CW], i, v[best*CW +: CW], best)))
                    best = i;
            end
            used[best] = 1'b1;
            if (v[best*CW +: PT_W] != '0) begin
                it.empty[s]                 = 1'b0;
                it.pt[s*PT_W +: PT_W]       = v[best*CW +: PT_W];
                it.data[s*DATA_W +: DATA_W] = v[best*CW + PT_W +: DATA_W];
                it.rank[s*RANK_W +: RANK_W] = v[best*CW + PT_W + DATA_W +: RANK_W];
                it.aux[s*AUX_W +: AUX_W]    = v[best*CW + PT_W + DATA_W + RANK_W +: AUX_W];
                it.idx[s*IDX_W +: IDX_W]    = IDX_W'(best);
            end
        end
        queue_q.push_back(it);
    endtask

    task automatic idle(input string req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b0;
        all_in   = '0;
        it       = '{default: '0};
        it.valid = 1'b0;
        it.req   = req;
        it.cyc   = cycle;
        queue_q.push_back(it);
    endtask

    // monitor: compares results one cycle after they were driven
    always @(negedge clk) begin
        if (rst_n && queue_q.size() > 0 && queue_q[0].cyc < cycle) begin
            item_t it;
            it = queue_q.pop_front();
            check({it.req, " R6"}, "out_valid", 64'(out_valid), 64'(it.valid));
            if (it.valid) begin
                for (int s = 0; s < N_OUT; s++) begin
                    check(it.req, $sformatf("slot%0d empty", s), 64'(out_empty[s]), 64'(it.empty[s]));
                    check(it.req, $sformatf("slot%0d fields", s),
                          {out_pt[s*PT_W +: PT_W], out_data[s*DATA_W +: DATA_W],
                           out_rank[s*RANK_W +: RANK_W], out_aux[s*AUX_W +: AUX_W],
                           out_index[s*IDX_W +: IDX_W]},
                          {it.pt[s*PT_W +: PT_W], it.data[s*DATA_W +: DATA_W],
                           it.rank[s*RANK_W +: RANK_W], it.aux[s*AUX_W +: AUX_W],
                           it.idx[s*IDX_W +: IDX_W]});
                end
            end
        end
    end

    function automatic logic [31:0] step(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N_IN*CW-1:0] v;
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7", "out_valid", 64'(out_valid), 64'd0);
        check("R7", "out_empty", 64'(out_empty), 64'hF);
        check("R7", "fields", {out_pt, out_rank, out_index}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", "post-reset empty", 64'(out_empty), 64'hF);

        // R2 R8: distinct ranks
        for (int i = 0; i < N_IN; i++) v[i*CW +: CW] = mk(10 + i, 16 * i + 1, (i * 5) % 8 + 3, i % 4);
        drive(v, "R2 R8");
        // R3: all ranks equal -> indices 0..3
        for (int i = 0; i < N_IN; i++) v[i*CW +: CW] = mk(i + 1, i, 20, 3);
        drive(v, "R3");
        // R3: tie spanning regions (indices 1, 4, 6 share top rank)
        for (int i = 0; i < N_IN; i++) v[i*CW +: CW] = mk(5, i, 7, 1);
        v[6*CW +: CW] = mk(9, 66, 40, 2);
        v[4*CW +: CW] = mk(8, 44, 40, 1);
        v[1*CW +: CW] = mk(7, 11, 40, 3);
        drive(v, "R3 cross-region");
        // R4: empty records carry the maximum rank
        for (int i = 0; i < N_IN; i++) v[i*CW +: CW] = (i % 2 == 0) ? mk(0, 255, 63, 3) : mk(i, i, 2, 1);
        drive(v, "R4");
        // R5 R9: only two filled
        v = '0;
        v[7*CW +: CW] = mk(100, 7, 9, 2);
        v[0*CW +: CW] = mk(50, 3, 9, 1);
        v[3*CW +: CW] = mk(0, 99, 50, 3);
        drive(v, "R5 R9");
        // R5: everything empty, junk in other fields
        for (int i = 0; i < N_IN; i++) v[i*CW +: CW] = mk(0, 200 + i, 60, 3);
        drive(v, "R5");
        // R1: one filled record at each joined position
        for (int p = 0; p < N_IN; p++) begin
            v = '0;
            v[p*CW +: CW] = mk(p + 1, 17 * p, 30, p % 4);
            drive(v, "R1");
        end
        // R6: valid drops
        idle("R6");
        idle("R6");
        // random, small rank range for frequent ties
        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < N_IN; i++) begin
                lfsr = step(lfsr);
                v[i*CW +: CW] = mk((lfsr[3:0] < 3) ? 0 : int'(lfsr[12:4]), int'(lfsr[20:13]),
                                   int'(lfsr[23:21]), int'(lfsr[25:24]));
            end
            drive(v, "R2 R3 R4 R9");
            if (n % 7 == 0) idle("R6");
        end
        idle("R6");
        repeat (3) @(negedge clk);
        check("R6", "queue drained", 64'(queue_q.size()), 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule